// File: doc/BRIEF.md
# Component Configuration Space Responder

This block is the slave logic inside one component that answers reads of the shared, read-only configuration space. Every component on the bus carries an 8-bit virtual identifier (VID). A configuration read carries a VID, a byte offset and byte-lane enables. The component answers only when the request selects its own VID. The answer is a small block of identity data made from strapped inputs: a four-character type code, the component's physical slot number (PID), the VID of the bus master it hangs off, and bit-inverted copies of those two bytes. Software can compare each byte with its inverted copy to detect two components that share one VID. A master VID of 0xFF means the component sits directly on the root bus master.

The VID is loaded from a parameter at reset and can be rewritten at run time through a one-byte write port. A component whose VID is 0xFF is invisible and never answers. Read data is registered and appears one clock after the request. When the block is not answering, its data output is all ones. This lets the outputs of many responders be merged with a bitwise AND. Any location or byte lane that is not implemented also reads as all ones.

Top module: `cfg_space_responder`

## Requirements
- R1: After reset the stored VID equals the parameter RST_VID (default 0x3C), `rd_drive_o` is 0 and `rd_data_o` is 0xFFFFFFFF.
- R2: A write on `vid_we_i` replaces the stored VID at that clock edge. A read issued in the following cycle is compared against the new VID. A read in the same cycle as the write is compared against the old VID.
- R3: While the stored VID is 0xFF the block never answers, even for a request whose VID is 0xFF.
- R4: A request answers exactly when `cfg_sel_i` is 1, `cfg_vid_i` equals the stored VID, and the stored VID is not 0xFF. The answer appears on `rd_data_o` with `rd_drive_o` = 1 one clock after the request. In every other cycle `rd_drive_o` is 0 and `rd_data_o` is 0xFFFFFFFF.
- R5: A word read at offsets 0x00-0x03 returns `type_id_i`, little-endian: bits 7:0 are the byte at offset 0 (the first character), and bits 31:24 are the byte at offset 3.
- R6: A word read at offsets 0x04-0x07 returns PID in bits 7:0, master VID in bits 15:8, inverted PID in bits 23:16 and inverted master VID in bits 31:24.
- R7: Byte lane i (bits 8i+7:8i) carries data only when `cfg_be_i[i]` is 1; a disabled lane reads 0xFF. Byte, halfword and word reads are all formed this way.
- R8: With EXT_EN = 1 (the default), offsets 0x08-0x0B return `ext1_i` and offsets 0x0C-0x0F return `ext2_i`, both laid out like R5. With EXT_EN = 0, offset bit 3 is not decoded.
- R9: An answering read at any offset of 0x10 or above returns 0xFFFFFFFF with `rd_drive_o` = 1.
- R10: Offset bits 1:0 do not affect the answer; lane selection is by `cfg_be_i` alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_sel_i | input | 1 | Configuration-space read request |
| cfg_vid_i | input | 8 | VID addressed by the request |
| cfg_off_i | input | CFG_AW (8) | Byte offset within the configuration space |
| cfg_be_i | input | 4 | Byte-lane enables, bit i for bits 8i+7:8i |
| vid_we_i | input | 1 | Load a new VID |
| vid_wd_i | input | 8 | VID value to load |
| type_id_i | input | 32 | Strapped four-character type code, first character in bits 7:0 |
| pid_i | input | 8 | Strapped physical slot number |
| mvid_i | input | 8 | Strapped VID of the bus master (0xFF for the root master) |
| ext1_i | input | 32 | Strapped first extension code |
| ext2_i | input | 32 | Strapped second extension code |
| rd_data_o | output | 32 | Registered read data, all ones when not answering |
| rd_drive_o | output | 1 | High in the cycle the block answers |

## Verification
The hardest case to reach is a VID rewrite in the same cycle as a read. The read must match the old value, and a read one cycle later must match the new value. The bench forces this pairing directly, including a move into and out of the hidden value 0xFF. Constrained random traffic then mixes writes with reads that are biased toward the current VID. In the random phase the straps, offsets, including ones above 0x0F, and lane enables all vary independently.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = BYTE_W * LANES;

  localparam logic [BYTE_W-1:0] VID_HIDDEN = '1;
  localparam logic [DATA_W-1:0] OPEN_BUS   = '1;

  // Word index within the 16-byte identity block
  typedef enum logic [1:0] {
    WORD_TYPE = 2'd0,
    WORD_IDS  = 2'd1,
    WORD_EXT1 = 2'd2,
    WORD_EXT2 = 2'd3
  } word_e;

  typedef struct packed {
    logic [DATA_W-1:0] type_id;
    logic [BYTE_W-1:0] pid;
    logic [BYTE_W-1:0] mvid;
    logic [DATA_W-1:0] ext1;
    logic [DATA_W-1:0] ext2;
  } straps_t;

  // Identity word: the two IDs in the low lanes, their complements above
  function automatic logic [DATA_W-1:0] ids_word(input logic [BYTE_W-1:0] pid,
                                                 input logic [BYTE_W-1:0] mvid);
    return {~mvid, ~pid, mvid, pid};
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/cfg_vid_reg.sv
module cfg_vid_reg #(
  parameter int              VID_W   = 8,
  parameter logic [VID_W-1:0] RST_VID = 8'h3C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [VID_W-1:0] wd_i,
  output logic [VID_W-1:0] vid_o,
  output logic             visible_o
);

  logic [VID_W-1:0] vid_q;
  logic [VID_W-1:0] vid_d;
  logic             vid_en;

  always_comb begin
    vid_en = we_i;
    vid_d  = wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q <= RST_VID;
    end else if (vid_en) begin
      vid_q <= vid_d;
    end
  end

  assign vid_o     = vid_q;
  assign visible_o = (vid_q != {VID_W{1'b1}});

endmodule

// File: rtl/cfg_word_mux.sv
module cfg_word_mux
  import cfg_space_pkg::*;
#(
  parameter int AW     = 8,
  parameter bit EXT_EN = 1'b1
) (
  input  logic [AW-1:0]     off_i,
  input  straps_t           straps_i,
  output logic [DATA_W-1:0] word_o
);

  localparam int HI_W = AW - 4;

  logic              in_block;
  logic [DATA_W-1:0] sel_word;
  word_e             widx;

  assign in_block = (off_i[AW-1:4] == {HI_W{1'b0}});

  generate
    if (EXT_EN) begin : g_ext
      always_comb begin
        widx = word_e'(off_i[3:2]);
        case (widx)
          WORD_TYPE: sel_word = straps_i.type_id;
          WORD_IDS:  sel_word = ids_word(straps_i.pid, straps_i.mvid);
          WORD_EXT1: sel_word = straps_i.ext1;
          default:   sel_word = straps_i.ext2;
        endcase
      end
    end else begin : g_noext
      always_comb begin
        widx = off_i[2] ? WORD_IDS : WORD_TYPE;
        sel_word = (widx == WORD_IDS) ? ids_word(straps_i.pid, straps_i.mvid)
                                      : straps_i.type_id;
      end
    end
  endgenerate

  assign word_o = in_block ? sel_word : OPEN_BUS;

endmodule

// File: rtl/cfg_lane_mask.sv
module cfg_lane_mask
  import cfg_space_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [LANES-1:0]  be_i,
  output logic [DATA_W-1:0] word_o
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign word_o[g*BYTE_W +: BYTE_W] =
        be_i[g] ? word_i[g*BYTE_W +: BYTE_W] : {BYTE_W{1'b1}};
    end
  endgenerate

endmodule

// File: rtl/cfg_space_responder.sv
module cfg_space_responder
  import cfg_space_pkg::*;
#(
  parameter int         CFG_AW  = 8,
  parameter bit         EXT_EN  = 1'b1,
  parameter logic [7:0] RST_VID = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel_i,
  input  logic [7:0]        cfg_vid_i,
  input  logic [CFG_AW-1:0] cfg_off_i,
  input  logic [3:0]        cfg_be_i,
  input  logic              vid_we_i,
  input  logic [7:0]        vid_wd_i,
  input  logic [31:0]       type_id_i,
  input  logic [7:0]        pid_i,
  input  logic [7:0]        mvid_i,
  input  logic [31:0]       ext1_i,
  input  logic [31:0]       ext2_i,
  output logic [31:0]       rd_data_o,
  output logic              rd_drive_o
);

  logic              rst_sync_n;
  logic [7:0]        vid_q;
  logic              vid_visible;
  straps_t           straps;
  logic [DATA_W-1:0] raw_word;
  logic [DATA_W-1:0] lane_word;
  logic              hit;
  logic [DATA_W-1:0] resp_data_d, resp_data_q;
  logic              resp_drv_d, resp_drv_q;

  cfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_sync_n_o (rst_sync_n)
  );

  cfg_vid_reg #(.VID_W(8), .RST_VID(RST_VID)) u_vid (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we_i      (vid_we_i),
    .wd_i      (vid_wd_i),
    .vid_o     (vid_q),
    .visible_o (vid_visible)
  );

  always_comb begin
    straps.type_id = type_id_i;
    straps.pid     = pid_i;
    straps.mvid    = mvid_i;
    straps.ext1    = ext1_i;
    straps.ext2    = ext2_i;
  end

  cfg_word_mux #(.AW(CFG_AW), .EXT_EN(EXT_EN)) u_mux (
    .off_i    (cfg_off_i),
    .straps_i (straps),
    .word_o   (raw_word)
  );

  cfg_lane_mask u_mask (
    .word_i (raw_word),
    .be_i   (cfg_be_i),
    .word_o (lane_word)
  );

  // Address match against the VID held before any same-cycle write
  always_comb begin
    hit         = cfg_sel_i && vid_visible && (cfg_vid_i == vid_q);
    resp_drv_d  = hit;
    resp_data_d = hit ? lane_word : OPEN_BUS;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      resp_data_q <= OPEN_BUS;
      resp_drv_q  <= 1'b0;
    end else begin
      resp_data_q <= resp_data_d;
      resp_drv_q  <= resp_drv_d;
    end
  end

  assign rd_data_o  = resp_data_q;
  assign rd_drive_o = resp_drv_q;

endmodule

// File: rtl/cfg_space_responder_chk.sv
module cfg_space_responder_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          cfg_sel_i,
  input logic [7:0]    cfg_vid_i,
  input logic [AW-1:0] cfg_off_i,
  input logic [3:0]    cfg_be_i,
  input logic          vid_we_i,
  input logic [7:0]    vid_wd_i,
  input logic [7:0]    vid_q,
  input logic [31:0]   rd_data_o,
  input logic          rd_drive_o
);

  AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_sel_i |=> (!rd_drive_o && rd_data_o == 32'hFFFF_FFFF)); // R4

  AST_MISMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_vid_i != vid_q) |=> !rd_drive_o); // R4

  AST_HIDDEN_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vid_q == 8'hFF) |=> !rd_drive_o); // R3

  AST_VID_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vid_we_i |=> (vid_q == $past(vid_wd_i))); // R2

  AST_VID_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !vid_we_i |=> $stable(vid_q)); // R2

  AST_LANE0_MASK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_sel_i && !cfg_be_i[0]) |=> (rd_data_o[7:0] == 8'hFF)); // R7

  AST_LANE3_MASK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_sel_i && !cfg_be_i[3]) |=> (rd_data_o[31:24] == 8'hFF)); // R7

  AST_INVERSE_PAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_sel_i && cfg_vid_i == vid_q && vid_q != 8'hFF &&
     cfg_off_i[AW-1:2] == 1 && cfg_be_i == 4'hF)
    |=> (rd_drive_o && rd_data_o[23:16] == ~rd_data_o[7:0] &&
         rd_data_o[31:24] == ~rd_data_o[15:8])); // R6

  AST_HIGH_OPEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_sel_i && cfg_vid_i == vid_q && vid_q != 8'hFF && cfg_off_i[AW-1:4] != 0)
    |=> (rd_drive_o && rd_data_o == 32'hFFFF_FFFF)); // R9

endmodule

bind cfg_space_responder cfg_space_responder_chk #(.AW(CFG_AW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_sel_i  (cfg_sel_i),
  .cfg_vid_i  (cfg_vid_i),
  .cfg_off_i  (cfg_off_i),
  .cfg_be_i   (cfg_be_i),
  .vid_we_i   (vid_we_i),
  .vid_wd_i   (vid_wd_i),
  .vid_q      (vid_q),
  .rd_data_o  (rd_data_o),
  .rd_drive_o (rd_drive_o)
);

// File: tb/cfg_space_responder_test.sv
`timescale 1ns/1ps
module cfg_space_responder_test;

  localparam logic [7:0] RST_VID = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_sel_i;
  logic [7:0]  cfg_vid_i;
  logic [7:0]  cfg_off_i;
  logic [3:0]  cfg_be_i;
  logic        vid_we_i;
  logic [7:0]  vid_wd_i;
  logic [31:0] type_id_i;
  logic [7:0]  pid_i;
  logic [7:0]  mvid_i;
  logic [31:0] ext1_i;
  logic [31:0] ext2_i;
  logic [31:0] rd_data_o;
  logic        rd_drive_o;

  int checks   = 0;
  int failures = 0;
  logic [7:0] vid_m;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_space_responder #(.CFG_AW(8), .EXT_EN(1'b1), .RST_VID(RST_VID)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel_i(cfg_sel_i), .cfg_vid_i(cfg_vid_i),
    .cfg_off_i(cfg_off_i), .cfg_be_i(cfg_be_i), .vid_we_i(vid_we_i),
    .vid_wd_i(vid_wd_i), .type_id_i(type_id_i), .pid_i(pid_i), .mvid_i(mvid_i),
    .ext1_i(ext1_i), .ext2_i(ext2_i), .rd_data_o(rd_data_o), .rd_drive_o(rd_drive_o)
  );

  function automatic logic [31:0] model(input logic [7:0] off, input logic [3:0] be);
    logic [31:0] w;
    if (off[7:4] != 4'h0) w = 32'hFFFF_FFFF;
    else begin
      case (off[3:2])
        2'd0: w = type_id_i;
        2'd1: w = {~mvid_i, ~pid_i, mvid_i, pid_i};
        2'd2: w = ext1_i;
        default: w = ext2_i;
      endcase
    end
    for (int i = 0; i < 4; i++) if (!be[i]) w[i*8 +: 8] = 8'hFF;
    return w;
  endfunction

  task automatic check(input string tag, input logic drv, input logic edrv,
                       input logic [31:0] d, input logic [31:0] ed);
    checks++;
    if (drv !== edrv || d !== ed) begin
      failures++;
      $display("FAIL %s: drive=%0b data=%08h expected drive=%0b data=%08h",
               tag, drv, d, edrv, ed);
    end
  endtask

  task automatic rd(input string tag, input logic sel, input logic [7:0] vid,
                    input logic [7:0] off, input logic [3:0] be,
                    input logic we = 1'b0, input logic [7:0] wd = 8'h00);
    logic        edrv;
    logic [31:0] edat;
    @(negedge clk);
    cfg_sel_i = sel; cfg_vid_i = vid; cfg_off_i = off; cfg_be_i = be;
    vid_we_i = we; vid_wd_i = wd;
    edrv = sel && (vid == vid_m) && (vid_m != 8'hFF);
    edat = edrv ? model(off, be) : 32'hFFFF_FFFF;
    @(posedge clk); #1;
    if (we) vid_m = wd;
    check(tag, rd_drive_o, edrv, rd_data_o, edat);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: drive=%0b data=%08h expected completion", rd_drive_o, rd_data_o);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED_1234);
    rst_n = 1'b0;
    cfg_sel_i = 0; cfg_vid_i = 0; cfg_off_i = 0; cfg_be_i = 0;
    vid_we_i = 0; vid_wd_i = 0;
    type_id_i = {8'h30, 8'h67, 8'h66, 8'h43};
    pid_i = 8'h05; mvid_i = 8'h81;
    ext1_i = 32'h1122_3344; ext2_i = 32'hA5B6_C7D8;
    vid_m = RST_VID;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", rd_drive_o, 1'b0, rd_data_o, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    rd("R1 default VID answers", 1, RST_VID, 8'h00, 4'hF);
    rd("R5 type word", 1, RST_VID, 8'h00, 4'hF);
    rd("R6 id word", 1, RST_VID, 8'h04, 4'hF);
    rd("R7 byte at 0x05", 1, RST_VID, 8'h05, 4'b0010);
    rd("R7 halfword at 0x06", 1, RST_VID, 8'h06, 4'b1100);
    rd("R8 ext1 word", 1, RST_VID, 8'h08, 4'hF);
    rd("R8 ext2 word", 1, RST_VID, 8'h0C, 4'hF);
    rd("R9 offset 0x10 open", 1, RST_VID, 8'h10, 4'hF);
    rd("R9 offset 0x80 open", 1, RST_VID, 8'h80, 4'hF);
    rd("R10 low offset bits ignored", 1, RST_VID, 8'h07, 4'b0001);
    rd("R4 wrong VID silent", 1, 8'h3D, 8'h00, 4'hF);
    rd("R4 no select silent", 0, RST_VID, 8'h00, 4'hF);
    rd("R2 same-cycle old VID", 1, RST_VID, 8'h04, 4'hF, 1'b1, 8'h21);
    rd("R2 old VID gone", 1, RST_VID, 8'h04, 4'hF);
    rd("R2 new VID next cycle", 1, 8'h21, 8'h00, 4'hF);
    rd("R3 write hidden VID", 1, 8'h21, 8'h04, 4'hF, 1'b1, 8'hFF);
    rd("R3 hidden VID silent", 1, 8'hFF, 8'h00, 4'hF);
    rd("R3 hidden VID silent at ids", 1, 8'hFF, 8'h04, 4'hF);
    rd("R2 leave hidden VID", 1, 8'hFF, 8'h00, 4'hF, 1'b1, 8'h00);
    rd("R2 VID zero answers", 1, 8'h00, 8'h04, 4'hF);
    mvid_i = 8'hFF; pid_i = 8'h00;
    rd("R6 root master ids", 1, 8'h00, 8'h04, 4'hF);

    for (int n = 0; n < 800; n++) begin
      logic       s, w;
      logic [7:0] v, o, d;
      logic [3:0] b;
      if ($urandom % 16 == 0) begin
        type_id_i = $urandom; pid_i = $urandom; mvid_i = $urandom;
        ext1_i = $urandom; ext2_i = $urandom;
      end
      s = ($urandom % 4) != 0;
      v = ($urandom % 3 == 0) ? 8'($urandom) : vid_m;
      if ($urandom % 8 == 0) v = 8'hFF;
      o = ($urandom % 4 == 0) ? 8'($urandom) : {4'h0, 4'($urandom)};
      b = 4'($urandom);
      w = ($urandom % 10) == 0;
      d = ($urandom % 6 == 0) ? 8'hFF : 8'($urandom);
      rd("R4 random read", s, v, o, b, w, d);
    end

    @(negedge clk);
    cfg_sel_i = 0; vid_we_i = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule